// File: doc/BRIEF.md
# SDRAM-Backed Read-Only Memory Emulator with Bank Rotation

This block lets a single-data-rate SDRAM stand in for a parallel read-only memory whose host issues random reads back to back, each of which must complete inside a fixed window of `WIN` controller clocks, with no idle time left over for refresh. At power-up the image is written, word by word, into `NB` banks so that every bank holds an identical copy. After that, host reads rotate through the banks. While one bank serves the current read, the next bank in the rotation receives a row refresh made from an explicit activate and a later precharge. Refresh therefore happens inside every read window and never delays the host.

Each read window occupies a fixed sequence of command slots. Slot 0 activates the read row. Slot 1 activates the refresh row in the next bank. Slot `TRCD` issues a read with auto-precharge. Slot `1+TRAS` precharges the refresh bank. The refresh row counter advances once per full rotation through the banks. The host strobe and address are assumed to be already synchronised to `clk`. The SDRAM mode register is assumed to be programmed before loading starts. Commands appear on `sd_cmd` as the active-low triple {RAS, CAS, WE}, and chip select is held active outside the block.

Top module: `sdram_rom_emu`

## Requirements
- R1: While reset is held, and after it is released, `sd_cmd` is NOP (3'b111), `host_valid` is 0, `rom_ready` is 0 and `load_ready` is 1.
- R2: Each load word accepted (`load_valid` while `load_ready` is high) is written to every copy bank 0..NB-1, at row `load_addr[ROW_W+COL_W-1:COL_W]` and column `load_addr[COL_W-1:0]`. Each write is ACT (3'b011) followed by WRITE (3'b100) with `sd_addr[AP_BIT]` set and `sd_dq_oe` high. `load_ready` is 0 while a word is being written.
- R3: `rom_ready` rises once the word flagged by `load_last` has been written to every copy, and it then stays high. Load strobes after that point issue no command.
- R4: A host read strobe while `rom_ready` is 0 issues no SDRAM command and returns no data.
- R5: A host read issues ACT to the read bank, with the row taken from the upper address bits. It then issues READ (3'b101) to the same bank exactly TRCD clocks later, with the column in `sd_addr[COL_W-1:0]` and `sd_addr[AP_BIT]`=1.
- R6: Successive served reads use banks 0, 1, ..., NB-1, 0, ... in that order.
- R7: Each read window also activates bank (read bank + 1) mod NB one clock after the read ACT. It precharges that bank (3'b010, `sd_addr[AP_BIT]`=0) exactly TRAS clocks after that activate. No auto-refresh command is ever issued.
- R8: The refresh row equals (number of reads served before the window / NB) mod 2^ROW_W. Every row of every bank is therefore activated within NB·2^ROW_W consecutive reads.
- R9: `host_data` is the word stored at the requested address. `host_valid` is high for exactly one clock, TRCD+CL+1 clocks after the edge that accepts the strobe.
- R10: Strobes spaced WIN clocks apart are all served. A strobe that arrives while a read window is running, except in the window's last clock, is ignored.
- R11: No ACT is issued to a bank with an open row. No READ or WRITE is issued to a bank without an open row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_valid | input | 1 | Image word offered |
| load_last | input | 1 | Offered word is the final one |
| load_addr | input | ROW_W+COL_W | Image word address |
| load_data | input | DW | Image word |
| load_ready | output | 1 | Loader can accept a word |
| rom_ready | output | 1 | Image resident, host reads served |
| host_rd | input | 1 | Synchronised host read strobe |
| host_addr | input | ROW_W+COL_W | Host read address {row, column} |
| host_data | output | DW | Read data |
| host_valid | output | 1 | One-clock data-valid strobe |
| sd_cmd | output | 3 | {RAS, CAS, WE}, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | SD_AW | Row / column address, auto-precharge at AP_BIT |
| sd_dq_out | output | DW | Write data |
| sd_dq_oe | output | 1 | Drive enable for write data |
| sd_dq_in | input | DW | Data returned by the SDRAM |

## Verification
The bench builds the block with ROW_W=4, COL_W=3, CL=3, NB=3 and an 8-clock window, which gives 16 rows per bank and a 128-word image. With that few rows, a complete refresh sweep of all 48 bank-row pairs fits in 48 reads, so the bench can check the refresh row counter through its wrap and confirm coverage of every row in every bank. The longer CAS latency pushes data capture to the sixth clock of the window, which tests the deepest capture point the window allows.

// File: rtl/rom_emu_pkg.sv
package rom_emu_pkg;
   // {RAS, CAS, WE}, active low
   typedef enum logic [2:0] {
      CMD_PRE   = 3'b010,
      CMD_ACT   = 3'b011,
      CMD_WRITE = 3'b100,
      CMD_READ  = 3'b101,
      CMD_NOP   = 3'b111
   } sd_cmd_e;
endpackage

// File: rtl/rom_emu_rotator.sv
module rom_emu_rotator #(
   parameter int NB    = 3,
   parameter int BA_W  = 2,
   parameter int ROW_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [BA_W-1:0]  rd_bank,
   output logic [BA_W-1:0]  ref_bank,
   output logic [ROW_W-1:0] ref_row
);
   localparam logic [BA_W-1:0] LAST_BANK = BA_W'(NB - 1);

   logic wrap;
   assign wrap = (rd_bank == LAST_BANK);

   generate
      if ((1 << BA_W) == NB) begin : g_pow2
         assign ref_bank = rd_bank + 1'b1;
      end else begin : g_cmp
         assign ref_bank = wrap ? '0 : rd_bank + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_bank <= '0;
         ref_row <= '0;
      end else if (step) begin
         rd_bank <= ref_bank;
         if (wrap) ref_row <= ref_row + 1'b1;
      end
   end

   AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (rd_bank <= LAST_BANK)) else $error("bank out of range"); // R6
endmodule

// File: rtl/rom_emu_sequencer.sv
module rom_emu_sequencer #(
   parameter int WIN    = 8,
   parameter int NB     = 3,
   parameter int BA_W   = 2,
   parameter int SLOT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_rd,
   input  logic              start_ld,
   input  logic              ld_last,
   output logic              busy,
   output logic              is_load,
   output logic              win_last,
   output logic              ready,
   output logic [SLOT_W-1:0] slot,
   output logic [BA_W-1:0]   ld_bank
);
   localparam logic [SLOT_W-1:0] SLOT_END  = SLOT_W'(WIN - 1);
   localparam logic [BA_W-1:0]   LAST_BANK = BA_W'(NB - 1);

   logic last_q;

   assign win_last = busy && (slot == SLOT_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         is_load <= 1'b0;
         ready   <= 1'b0;
         last_q  <= 1'b0;
         slot    <= '0;
         ld_bank <= '0;
      end else if (start_rd || start_ld) begin
         busy    <= 1'b1;
         slot    <= '0;
         is_load <= start_ld;
         ld_bank <= '0;
         if (start_ld) last_q <= ld_last;
      end else if (win_last) begin
         if (is_load && ld_bank != LAST_BANK) begin
            slot    <= '0;
            ld_bank <= ld_bank + 1'b1;
         end else begin
            busy <= 1'b0;
            if (is_load && last_q) ready <= 1'b1;
         end
      end else if (busy) begin
         slot <= slot + 1'b1;
      end
   end

   AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready) else $error("ready dropped"); // R3
endmodule

// File: rtl/rom_emu_capture.sv
module rom_emu_capture #(
   parameter int DW = 16,
   parameter int CL = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_issue,
   input  logic [DW-1:0] dq_in,
   output logic [DW-1:0] data,
   output logic          valid
);
   logic [CL-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe  <= '0;
         valid <= 1'b0;
         data  <= '0;
      end else begin
         pipe  <= {pipe[CL-2:0], rd_issue};
         valid <= pipe[CL-1];
         if (pipe[CL-1]) data <= dq_in;
      end
   end

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid) else $error("valid longer than one clock"); // R9
   AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $past(rd_issue, CL + 1)) else $error("valid without read"); // R9
endmodule

// File: rtl/sdram_rom_emu.sv
module sdram_rom_emu
   import rom_emu_pkg::*;
#(
   parameter int ROW_W            = 13,
   parameter int COL_W            = 9,
   parameter int DW               = 16,
   parameter int NB               = 3,
   parameter int BA_W             = 2,
   parameter int SD_AW            = 13,
   parameter int AP_BIT           = 10,
   parameter int WIN              = 8,
   parameter int TRCD             = 2,
   parameter int TRAS             = 5,
   parameter int TRP              = 2,
   parameter int CL               = 2,
   parameter int REFRESH_MS       = 64,
   parameter int MIN_READS_PER_MS = 1000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_valid,
   input  logic                   load_last,
   input  logic [ROW_W+COL_W-1:0] load_addr,
   input  logic [DW-1:0]          load_data,
   output logic                   load_ready,
   output logic                   rom_ready,
   input  logic                   host_rd,
   input  logic [ROW_W+COL_W-1:0] host_addr,
   output logic [DW-1:0]          host_data,
   output logic                   host_valid,
   output logic [2:0]             sd_cmd,
   output logic [BA_W-1:0]        sd_ba,
   output logic [SD_AW-1:0]       sd_addr,
   output logic [DW-1:0]          sd_dq_out,
   output logic                   sd_dq_oe,
   input  logic [DW-1:0]          sd_dq_in
);
   localparam int HAW    = ROW_W + COL_W;
   localparam int SLOT_W = $clog2(WIN);
   localparam logic [SLOT_W-1:0] S_ACT = '0;
   localparam logic [SLOT_W-1:0] S_REF = SLOT_W'(1);
   localparam logic [SLOT_W-1:0] S_RW  = SLOT_W'(TRCD);
   localparam logic [SLOT_W-1:0] S_PRE = SLOT_W'(1 + TRAS);
   localparam longint ROW_BANKS = longint'(1 << ROW_W) * NB;
   localparam longint READ_BUDGET = longint'(MIN_READS_PER_MS) * REFRESH_MS;

   initial begin
      if (NB < 3 || NB > (1 << BA_W)) $fatal(1, "copy bank count out of range");
      if (CL != 2 && CL != 3) $fatal(1, "CAS latency must be 2 or 3");
      if (TRCD < 2) $fatal(1, "refresh activate needs a slot before the read");
      if (1 + TRAS <= TRCD) $fatal(1, "refresh precharge collides with read");
      if (1 + TRAS + TRP > WIN) $fatal(1, "refresh does not fit the window");
      if (TRCD + CL > WIN - 1) $fatal(1, "data capture falls outside the window");
      if (ROW_W > SD_AW || COL_W > AP_BIT || AP_BIT >= SD_AW) $fatal(1, "address fields do not fit");
      if (ROW_BANKS > READ_BUDGET) $fatal(1, "refresh sweep exceeds refresh period at minimum read rate");
   end

   logic              busy, is_load, win_last, ready;
   logic [SLOT_W-1:0] slot;
   logic [BA_W-1:0]   ld_bank, rd_bank, ref_bank, act_ba;
   logic [ROW_W-1:0]  ref_row, lat_row;
   logic [COL_W-1:0]  lat_col;
   logic [DW-1:0]     lat_data;
   logic              start_rd, start_ld;
   sd_cmd_e           cmd_c;

   assign load_ready = !ready && !busy;
   assign rom_ready  = ready;
   assign start_ld   = load_ready && load_valid;
   assign start_rd   = ready && host_rd && (!busy || win_last);

   rom_emu_sequencer #(.WIN(WIN), .NB(NB), .BA_W(BA_W), .SLOT_W(SLOT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .start_ld(start_ld),
      .ld_last(load_last), .busy(busy), .is_load(is_load), .win_last(win_last),
      .ready(ready), .slot(slot), .ld_bank(ld_bank));

   rom_emu_rotator #(.NB(NB), .BA_W(BA_W), .ROW_W(ROW_W)) u_rot (
      .clk(clk), .rst_n(rst_n), .step(win_last && !is_load),
      .rd_bank(rd_bank), .ref_bank(ref_bank), .ref_row(ref_row));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_row  <= '0;
         lat_col  <= '0;
         lat_data <= '0;
      end else if (start_ld) begin
         lat_row  <= load_addr[HAW-1:COL_W];
         lat_col  <= load_addr[COL_W-1:0];
         lat_data <= load_data;
      end else if (start_rd) begin
         lat_row  <= host_addr[HAW-1:COL_W];
         lat_col  <= host_addr[COL_W-1:0];
      end
   end

   assign act_ba = is_load ? ld_bank : rd_bank;

   always_comb begin
      cmd_c    = CMD_NOP;
      sd_ba    = '0;
      sd_addr  = '0;
      sd_dq_oe = 1'b0;
      if (busy) begin
         if (slot == S_ACT) begin
            cmd_c   = CMD_ACT;
            sd_ba   = act_ba;
            sd_addr = SD_AW'(lat_row);
         end else if (!is_load && slot == S_REF) begin
            cmd_c   = CMD_ACT;
            sd_ba   = ref_bank;
            sd_addr = SD_AW'(ref_row);
         end else if (slot == S_RW) begin
            cmd_c           = is_load ? CMD_WRITE : CMD_READ;
            sd_ba           = act_ba;
            sd_addr         = SD_AW'(lat_col);
            sd_addr[AP_BIT] = 1'b1;
            sd_dq_oe        = is_load;
         end else if (!is_load && slot == S_PRE) begin
            cmd_c = CMD_PRE;
            sd_ba = ref_bank;
         end
      end
   end

   assign sd_cmd    = cmd_c;
   assign sd_dq_out = lat_data;

   rom_emu_capture #(.DW(DW), .CL(CL)) u_cap (
      .clk(clk), .rst_n(rst_n), .rd_issue(cmd_c == CMD_READ),
      .dq_in(sd_dq_in), .data(host_data), .valid(host_valid));

   AST_READ_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_READ) |-> ($past(sd_cmd, TRCD) == CMD_ACT && $past(sd_ba, TRCD) == sd_ba))
      else $error("read without activate"); // R5
   AST_PRE_AFTER_REF_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_PRE) |-> ($past(sd_cmd, TRAS) == CMD_ACT && $past(sd_ba, TRAS) == sd_ba))
      else $error("precharge not paired with refresh activate"); // R7
   AST_NO_READ_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_ready |-> (sd_cmd != CMD_READ)) else $error("read before image loaded"); // R4
   AST_NO_WRITE_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      rom_ready |-> (sd_cmd != CMD_WRITE)) else $error("write after image loaded"); // R3
endmodule

// File: tb/sim_sdram_rom_emu.sv
module sim_sdram_rom_emu;
   localparam int CLK_PERIOD = 10;
   localparam int ROW_W = 4, COL_W = 3, DW = 16, NB = 3, BA_W = 2, SD_AW = 13;
   localparam int WIN = 8, TRCD = 2, TRAS = 5, CL = 3;
   localparam int AW = ROW_W + COL_W, WORDS = 1 << AW, ROWS = 1 << ROW_W;
   localparam int LAT = TRCD + CL + 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic load_valid = 1'b0, load_last = 1'b0, host_rd = 1'b0;
   logic [AW-1:0] load_addr = '0, host_addr = '0;
   logic [DW-1:0] load_data = '0, host_data, sd_dq_out, sd_dq_in = '0;
   logic load_ready, rom_ready, host_valid, sd_dq_oe;
   logic [2:0] sd_cmd;
   logic [BA_W-1:0] sd_ba;
   logic [SD_AW-1:0] sd_addr;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_rom_emu #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .NB(NB), .BA_W(BA_W),
                   .SD_AW(SD_AW), .WIN(WIN), .TRCD(TRCD), .TRAS(TRAS), .CL(CL)) u0 (
      .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_last(load_last),
      .load_addr(load_addr), .load_data(load_data), .load_ready(load_ready),
      .rom_ready(rom_ready), .host_rd(host_rd), .host_addr(host_addr),
      .host_data(host_data), .host_valid(host_valid), .sd_cmd(sd_cmd), .sd_ba(sd_ba),
      .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

   int checks = 0, failures = 0, cyc = 0;
   bit done = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] img(input int a);
      return DW'((a * 37 + 11) ^ 16'h5A00);
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   always @(posedge clk) cyc++;

   // SDRAM model
   logic [DW-1:0] mem [NB][WORDS];
   bit  open_b [NB];
   int  open_row [NB];
   int  act_cyc [NB];
   bit  touched [NB][ROWS];
   int  rd_seen = 0, pre_seen = 0, wr_seen = 0, cmd_seen = 0, proto_err = 0;
   int  last_rd_ba = 0, pend_cnt = 0, m_b, m_idx;
   bit  prev_act = 0;
   logic [DW-1:0] pend_data;

   always @(posedge clk) begin
      if (pend_cnt > 0) begin
         if (pend_cnt == 1) sd_dq_in <= pend_data;
         pend_cnt--;
      end
      if (rst_n) begin
         m_b = int'(sd_ba);
         case (sd_cmd)
            3'b011: begin
               cmd_seen++;
               if (open_b[m_b]) proto_err++;
               open_b[m_b] = 1;
               open_row[m_b] = int'(sd_addr[ROW_W-1:0]);
               act_cyc[m_b] = cyc;
               touched[m_b][open_row[m_b]] = 1;
               if (prev_act) begin
                  check(open_row[m_b] == (rd_seen / NB) % ROWS, "R8 refresh row",
                        open_row[m_b], (rd_seen / NB) % ROWS);
                  check(m_b == (rd_seen % NB + 1) % NB, "R7 refresh bank", m_b, (rd_seen % NB + 1) % NB);
               end
            end
            3'b101: begin
               cmd_seen++;
               if (!open_b[m_b] || cyc - act_cyc[m_b] < TRCD) proto_err++;
               check(m_b == rd_seen % NB, "R6 rotation", m_b, rd_seen % NB);
               check(sd_addr[10] == 1'b1, "R5 auto-precharge", sd_addr[10], 1);
               m_idx = open_row[m_b] * (1 << COL_W) + int'(sd_addr[COL_W-1:0]);
               pend_data = mem[m_b][m_idx];
               pend_cnt = CL - 1;
               open_b[m_b] = 0;
               last_rd_ba = m_b;
               rd_seen++;
            end
            3'b100: begin
               cmd_seen++;
               wr_seen++;
               if (!open_b[m_b] || !sd_dq_oe || !sd_addr[10]) proto_err++;
               m_idx = open_row[m_b] * (1 << COL_W) + int'(sd_addr[COL_W-1:0]);
               mem[m_b][m_idx] = sd_dq_out;
               open_b[m_b] = 0;
            end
            3'b010: begin
               cmd_seen++;
               pre_seen++;
               if (!open_b[m_b]) proto_err++;
               check(m_b == (last_rd_ba + 1) % NB && !sd_addr[10], "R7 precharge bank",
                     m_b, (last_rd_ba + 1) % NB);
               open_b[m_b] = 0;
            end
            3'b111: ;
            default: proto_err++;
         endcase
         prev_act = (sd_cmd == 3'b011);
      end
   end

   // scoreboard
   logic [DW-1:0] exp_q [$];
   int cyc_q [$];
   bit prev_valid = 0;
   logic [DW-1:0] m_d;
   int m_c;

   always @(negedge clk) begin
      if (rst_n) begin
         if (host_valid) begin
            if (prev_valid) check(0, "R9 single-cycle valid", 1, 0);
            if (exp_q.size() == 0) check(0, "R10 unexpected data", 1, 0);
            else begin
               m_d = exp_q.pop_front();
               m_c = cyc_q.pop_front();
               check(host_data == m_d, "R9 data", host_data, m_d);
               check(cyc - m_c == LAT, "R9 latency", cyc - m_c, LAT);
            end
         end
         prev_valid = host_valid;
      end
   end

   task automatic host_read(input int a);
      exp_q.push_back(img(a));
      cyc_q.push_back(cyc);
      host_rd = 1'b1;
      host_addr = AW'(a);
      @(negedge clk);
      host_rd = 1'b0;
      repeat (WIN - 1) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int bad, w, r0;
      logic [6:0] lf;
      repeat (3) @(negedge clk);
      check(sd_cmd == 3'b111 && !host_valid && !rom_ready && load_ready, "R1 reset state", sd_cmd, 7);
      rst_n = 1'b1;
      @(negedge clk);
      check(sd_cmd == 3'b111 && !host_valid && !rom_ready && load_ready, "R1 after release", sd_cmd, 7);

      host_rd = 1'b1; host_addr = AW'(5);
      @(negedge clk); host_rd = 1'b0;
      repeat (10) @(negedge clk);
      check(cmd_seen == 0, "R4 read before ready", cmd_seen, 0);

      for (int a = 0; a < WORDS; a++) begin
         while (!load_ready) @(negedge clk);
         load_valid = 1'b1; load_addr = AW'(a); load_data = img(a);
         load_last = (a == WORDS - 1);
         @(negedge clk);
         load_valid = 1'b0; load_last = 1'b0;
         if (a == 0) begin
            check(!load_ready, "R2 busy while writing", load_ready, 0);
            check(!rom_ready, "R3 not ready early", rom_ready, 0);
         end
      end
      for (int i = 0; i < NB * WIN + 4 && !rom_ready; i++) @(negedge clk);
      check(rom_ready, "R3 ready after last word", rom_ready, 1);
      check(wr_seen == WORDS * NB, "R2 write count", wr_seen, WORDS * NB);
      for (int b = 0; b < NB; b++) begin
         bad = 0;
         for (int a = 0; a < WORDS; a++) if (mem[b][a] !== img(a)) bad++;
         check(bad == 0, "R2 copy content", bad, 0);
      end

      w = wr_seen;
      load_valid = 1'b1; load_addr = '0; load_data = 16'hFFFF;
      @(negedge clk); load_valid = 1'b0;
      repeat (10) @(negedge clk);
      check(wr_seen == w && !load_ready, "R3 load ignored after ready", wr_seen, w);

      for (int b = 0; b < NB; b++) for (int r = 0; r < ROWS; r++) touched[b][r] = 0;
      for (int a = 0; a < NB * ROWS; a++) host_read(a);
      bad = 0;
      for (int b = 0; b < NB; b++) for (int r = 0; r < ROWS; r++) if (!touched[b][r]) bad++;
      check(bad == 0, "R8 refresh coverage", bad, 0);

      lf = 7'h5A;
      for (int i = 0; i < 40; i++) begin
         host_read(int'(lf));
         lf = {lf[5:0], lf[6] ^ lf[5]};
      end
      host_read(WORDS - 1);
      host_read(0);
      for (int i = 0; i < 3; i++) host_read(77);

      r0 = rd_seen;
      exp_q.push_back(img(9)); cyc_q.push_back(cyc);
      host_rd = 1'b1; host_addr = AW'(9);
      @(negedge clk); host_rd = 1'b0;
      repeat (2) @(negedge clk);
      host_rd = 1'b1; host_addr = AW'(100);
      @(negedge clk); host_rd = 1'b0;
      repeat (WIN) @(negedge clk);
      check(rd_seen == r0 + 1, "R10 mid-window strobe ignored", rd_seen, r0 + 1);
      host_read(100);

      repeat (LAT + 4) @(negedge clk);
      check(exp_q.size() == 0, "R9 all reads answered", exp_q.size(), 0);
      check(pre_seen == rd_seen, "R7 one refresh per read", pre_seen, rd_seen);
      check(proto_err == 0, "R11 bank protocol", proto_err, 0);
      finish_run();
   end
endmodule